// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter

This block turns stereo sample pairs into a three-wire serial audio stream. The three wires are a bit clock, a channel-select clock and a data line. The bit clock comes from the system clock through a divider. Each frame is two slots of 32 bit clocks. The left slot is sent while the channel clock is low, and the right slot while it is high. Data changes on the falling edge of the bit clock, so a receiver can sample it on the rising edge.

Sample pairs arrive on a valid/ready port. The block raises ready for a single system cycle, just before each frame begins. A pair that is accepted in that cycle is the one the next frame carries. A run-time configuration sets two things:

- the word length: 16, 18, 20 or 24 bits;
- the bit order: most significant bit first or least significant bit first.

The configuration is taken only at frame boundaries. A mono flag sends the left word in both slots. If no pair is offered at a boundary, the previous pair is sent again and an underrun flag is raised for that frame.

Top module: `pcm_serial_tx`

## Requirements
- R1: After reset, sck, lrck, sdo, underrun and s_ready are all low.
- R2: sck is a square wave with a period of 2*CLK_DIV system clocks.
- R3: A frame is 64 sck periods, with lrck low for the first 32 (left) and high for the last 32 (right). sdo and lrck change only when sck falls.
- R4: With cfg_lsb_first=0, slot bit 0 (the first after the lrck edge) is zero. Slot bits 1..W carry sample bits W-1 down to 0, and the rest of the slot is zero. W is 16, 18, 20 or 24 for cfg_wlen codes 0, 1, 2 and 3.
- R5: With cfg_lsb_first=1, slot bits 1..W carry sample bits 0 up to W-1. Slot bit 0 and the bits after W are zero.
- R6: Sample bits at position W and above (of the 24-bit input) have no effect on sdo.
- R7: With s_mono=1 at acceptance, s_left is sent in both slots and s_right is ignored.
- R8: s_ready is high for exactly one system cycle per frame, every 128*CLK_DIV cycles. A pair accepted in that cycle is sent in the frame that follows.
- R9: cfg_wlen and cfg_lsb_first are sampled in the s_ready cycle. A change during a frame does not alter that frame.
- R10: If s_valid is low in the s_ready cycle, the frame repeats the last accepted pair (zero after reset). underrun is high for that frame, and low for a frame carrying a freshly accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Pair accepted this cycle (one cycle per frame) |
| s_left | input | 24 | Left sample, right-aligned |
| s_right | input | 24 | Right sample, right-aligned |
| s_mono | input | 1 | Send s_left in both slots |
| cfg_wlen | input | 2 | Word length code: 0=16, 1=18, 2=20, 3=24 |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| sck | output | 1 | Bit clock |
| lrck | output | 1 | Channel clock, low = left |
| sdo | output | 1 | Serial data |
| underrun | output | 1 | Current frame is a repeat |

## Verification
The bench sweeps every word length, both bit orders and mono against stereo. It uses samples whose bits above the word length are set, so a design that uses the wrong index range or forgets the padding shows stray ones in the tail of the slot. The configuration is changed during every frame, so a design that samples it continuously garbles the frame in flight. A pause in the supply checks that a design repeats the last pair and flags underrun, rather than sending zeros or stale flags. The slot decode checks the one-bit delay, so a data stream shifted by one bit is caught.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
   localparam int MAX_WORD = 24;

   typedef enum logic [1:0] {
      WL16 = 2'd0,
      WL18 = 2'd1,
      WL20 = 2'd2,
      WL24 = 2'd3
   } wlen_e;

   function automatic logic [4:0] wlen_bits(input logic [1:0] code);
      case (code)
         WL16:    wlen_bits = 5'd16;
         WL18:    wlen_bits = 5'd18;
         WL20:    wlen_bits = 5'd20;
         default: wlen_bits = 5'd24;
      endcase
   endfunction
endpackage

// File: rtl/pcm_clk_gen.sv
module pcm_clk_gen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic sck,
   output logic fall_evt
);
   logic tc;

   generate
      if (CLK_DIV == 1) begin : g_fast
         assign tc = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(CLK_DIV);
         logic [CW-1:0] cnt;
         assign tc = (cnt == CW'(CLK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)  cnt <= '0;
            else if (tc) cnt <= '0;
            else         cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  sck <= 1'b0;
      else if (tc) sck <= ~sck;
   end

   assign fall_evt = tc & sck;

   // R2: falling edges are never on back-to-back cycles
   assert_fall_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> !fall_evt);
endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
   import pcm_tx_pkg::*;
#(
   parameter int SLOT_BITS = 32,
   localparam int FRAME_BITS = 2 * SLOT_BITS,
   localparam int IDX_W = $clog2(FRAME_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_evt,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [MAX_WORD-1:0] s_left,
   input  logic [MAX_WORD-1:0] s_right,
   input  logic                s_mono,
   input  logic [1:0]          cfg_wlen,
   input  logic                cfg_lsb_first,
   output logic [IDX_W-1:0]    idx,
   output logic [MAX_WORD-1:0] cur_l,
   output logic [MAX_WORD-1:0] cur_r,
   output logic [1:0]          cur_wlen,
   output logic                cur_lsb,
   output logic                underrun
);
   logic last_bit;
   assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
   assign s_ready  = fall_evt & last_bit;

   always_ff @(posedge clk) begin
      if (!rst_n)        idx <= IDX_W'(FRAME_BITS - 1);
      else if (fall_evt) idx <= idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_l    <= '0;
         cur_r    <= '0;
         cur_wlen <= '0;
         cur_lsb  <= 1'b0;
         underrun <= 1'b0;
      end else if (s_ready) begin
         cur_wlen <= cfg_wlen;
         cur_lsb  <= cfg_lsb_first;
         underrun <= ~s_valid;
         if (s_valid) begin
            cur_l <= s_left;
            cur_r <= s_mono ? s_left : s_right;
         end
      end
   end

   // R8: ready lasts a single cycle
   assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !s_ready);
   // R10: underrun only moves at a frame boundary
   assert_underrun_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(underrun) |-> $past(s_ready));
endmodule

// File: rtl/pcm_bit_out.sv
module pcm_bit_out
   import pcm_tx_pkg::*;
#(
   parameter int SLOT_BITS = 32,
   localparam int FRAME_BITS = 2 * SLOT_BITS,
   localparam int IDX_W = $clog2(FRAME_BITS),
   localparam int POS_W = IDX_W - 1,
   localparam int IW = $clog2(MAX_WORD)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_evt,
   input  logic [IDX_W-1:0]    idx,
   input  logic [MAX_WORD-1:0] cur_l,
   input  logic [MAX_WORD-1:0] cur_r,
   input  logic [1:0]          cur_wlen,
   input  logic                cur_lsb,
   output logic                sdo,
   output logic                lrck
);
   logic [IDX_W-1:0]    nxt;
   logic [7:0]          pe, we, bi;
   logic [MAX_WORD-1:0] word;
   logic                in_data, bit_v;

   always_comb begin
      nxt     = idx + 1'b1;
      pe      = 8'(nxt[POS_W-1:0]);
      we      = 8'(wlen_bits(cur_wlen));
      word    = nxt[IDX_W-1] ? cur_r : cur_l;
      in_data = (pe != 8'd0) && (pe <= we);
      bi      = cur_lsb ? (pe - 8'd1) : (we - pe);
      bit_v   = in_data & word[bi[IW-1:0]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sdo  <= 1'b0;
         lrck <= 1'b0;
      end else if (fall_evt) begin
         sdo  <= bit_v;
         lrck <= nxt[IDX_W-1];
      end
   end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
   import pcm_tx_pkg::*;
#(
   parameter int CLK_DIV   = 2,
   parameter int SLOT_BITS = 32,
   localparam int IDX_W = $clog2(2 * SLOT_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [MAX_WORD-1:0] s_left,
   input  logic [MAX_WORD-1:0] s_right,
   input  logic                s_mono,
   input  logic [1:0]          cfg_wlen,
   input  logic                cfg_lsb_first,
   output logic                sck,
   output logic                lrck,
   output logic                sdo,
   output logic                underrun
);
   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (SLOT_BITS < MAX_WORD + 1 || (SLOT_BITS & (SLOT_BITS - 1)) != 0) begin : g_bad_slot
         $error("SLOT_BITS must be a power of two above the word size");
      end
   endgenerate

   logic                fall_evt;
   logic [IDX_W-1:0]    idx;
   logic [MAX_WORD-1:0] cur_l, cur_r;
   logic [1:0]          cur_wlen;
   logic                cur_lsb;

   pcm_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .sck(sck), .fall_evt(fall_evt));

   pcm_frame_ctl #(.SLOT_BITS(SLOT_BITS)) u_ctl (
      .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt),
      .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
      .s_mono(s_mono), .cfg_wlen(cfg_wlen), .cfg_lsb_first(cfg_lsb_first),
      .idx(idx), .cur_l(cur_l), .cur_r(cur_r), .cur_wlen(cur_wlen),
      .cur_lsb(cur_lsb), .underrun(underrun));

   pcm_bit_out #(.SLOT_BITS(SLOT_BITS)) u_out (
      .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .idx(idx),
      .cur_l(cur_l), .cur_r(cur_r), .cur_wlen(cur_wlen), .cur_lsb(cur_lsb),
      .sdo(sdo), .lrck(lrck));

   // R3: data and channel clock hold while sck stays high
   assert_sdo_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sdo));
   assert_lrck_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(lrck));
   // R3: a new frame starts in the left slot
   assert_left_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !lrck);
endmodule

// File: tb/pcm_serial_tx_bench.sv
module pcm_serial_tx_bench;
   localparam int DIV = 2;
   localparam int TARGET = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_valid = 1'b0, s_mono = 1'b0, cfg_lsb_first = 1'b0;
   logic [23:0] s_left = '0, s_right = '0;
   logic [1:0] cfg_wlen = '0;
   logic s_ready, sck, lrck, sdo, underrun;

   always #10 clk = ~clk;

   pcm_serial_tx #(.CLK_DIV(DIV), .SLOT_BITS(32)) u_pcm_serial_tx (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_left(s_left), .s_right(s_right), .s_mono(s_mono),
      .cfg_wlen(cfg_wlen), .cfg_lsb_first(cfg_lsb_first),
      .sck(sck), .lrck(lrck), .sdo(sdo), .underrun(underrun));

   int errors = 0, checks = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_slot(input logic [23:0] w, input logic [1:0] code, input logic lsb);
      int wl;
      logic [31:0] s;
      wl = (code == 2'd0) ? 16 : (code == 2'd1) ? 18 : (code == 2'd2) ? 20 : 24;
      s = '0;
      for (int p = 1; p <= wl; p++) s[31-p] = lsb ? w[p-1] : w[wl-p];
      return s;
   endfunction

   // expected frames, recorded at the boundary cycle
   logic [23:0] e_l [64], e_r [64];
   logic [1:0]  e_w [64];
   logic        e_lsb [64], e_unf [64], e_mono [64];
   int          n_exp = 0;
   logic [23:0] last_l = '0, last_r = '0;
   bit          took = 0;
   int          cyc = 0, last_ready_cyc = -1;

   // received stream
   logic        sck_q = 1'b0, sdo_q = 1'b0, lrck_q = 1'b0;
   bit          started = 0;
   int          bitnum = 0, rx_frames = 0, last_rise = -1;
   int          period_bad = 0, stable_bad = 0, lr_bad = 0;
   logic [31:0] sh = '0, got_l = '0;
   logic        got_unf = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (s_ready) begin
            if (last_ready_cyc >= 0)
               check(cyc - last_ready_cyc == 128 * DIV, "R8 ready spacing",
                     32'(cyc - last_ready_cyc), 32'(128 * DIV));
            last_ready_cyc = cyc;
            if (n_exp < 64) begin
               if (s_valid) begin
                  last_l = s_left;
                  last_r = s_mono ? s_left : s_right;
               end
               e_l[n_exp] = last_l; e_r[n_exp] = last_r;
               e_w[n_exp] = cfg_wlen; e_lsb[n_exp] = cfg_lsb_first;
               e_unf[n_exp] = !s_valid; e_mono[n_exp] = s_mono && s_valid;
               n_exp++;
            end
            took = s_valid;
         end
         if (sck && sck_q && (sdo != sdo_q || lrck != lrck_q)) stable_bad++;
         if (sck_q && !sck) started = 1;
         if (sck && !sck_q) begin
            if (last_rise >= 0 && cyc - last_rise != 2 * DIV) period_bad++;
            last_rise = cyc;
            if (started) begin
               if (bitnum == 0) got_unf = underrun;
               if (lrck != (bitnum >= 32)) lr_bad++;
               sh = {sh[30:0], sdo};
               if (bitnum == 31) got_l = sh;
               if (bitnum == 63) begin
                  if (rx_frames < n_exp) begin
                     string t;
                     logic [31:0] xl, xr;
                     xl = exp_slot(e_l[rx_frames], e_w[rx_frames], e_lsb[rx_frames]);
                     xr = exp_slot(e_r[rx_frames], e_w[rx_frames], e_lsb[rx_frames]);
                     t = e_mono[rx_frames] ? "R7 R6 R9" : (e_lsb[rx_frames] ? "R5 R6 R9" : "R4 R6 R9");
                     check(got_l == xl, {t, " left slot"}, got_l, xl);
                     check(sh == xr, {t, " right slot"}, sh, xr);
                     check(got_unf == e_unf[rx_frames], "R10 underrun flag",
                           32'(got_unf), 32'(e_unf[rx_frames]));
                  end
                  rx_frames++;
               end
               bitnum = (bitnum + 1) % 64;
            end
         end
      end
      sck_q = sck; sdo_q = sdo; lrck_q = lrck;
   end

   logic [23:0] lfsr = 24'hB3C5E1;
   function automatic logic [23:0] step(input logic [23:0] v);
      return {v[22:0], v[23] ^ v[22] ^ v[21] ^ v[16]};
   endfunction

   task automatic send(input logic [23:0] l, input logic [23:0] r, input logic mono,
                       input logic [1:0] wl, input logic lsb);
      @(posedge clk); #1;
      s_left = l; s_right = r; s_mono = mono; cfg_wlen = wl; cfg_lsb_first = lsb;
      s_valid = 1'b1;
      do @(posedge clk); while (!took);
      #1;
      took = 0;
      s_valid = 1'b0;
      // mid-frame change that must not reach the frame in flight (R9)
      cfg_wlen = ~wl; cfg_lsb_first = ~lsb; s_mono = ~mono;
   endtask

   bit timed_out = 0;

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check({sck, lrck, sdo, underrun, s_ready} == 5'b0, "R1 reset outputs",
            32'({sck, lrck, sdo, underrun, s_ready}), 32'h0);
      fork
         begin
            for (int wl = 0; wl < 4; wl++)
               for (int lb = 0; lb < 2; lb++)
                  for (int mo = 0; mo < 2; mo++) begin
                     logic [23:0] a, b;
                     lfsr = step(lfsr); a = lfsr | 24'hC00000;
                     lfsr = step(lfsr); b = lfsr | 24'h300000;
                     send(a, b, mo[0], wl[1:0], lb[0]);
                  end
            repeat (128 * DIV * 2 + 20) @(posedge clk);
            send(24'hFFFFFF, 24'h000001, 1'b0, 2'd3, 1'b0);
            send(24'h800001, 24'hFFFFFF, 1'b0, 2'd0, 1'b1);
            send(24'h5A5A5A, 24'hA5A5A5, 1'b0, 2'd2, 1'b0);
            wait (rx_frames >= TARGET);
         end
         begin
            repeat (200000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      check(!timed_out, "R8 watchdog", 32'(rx_frames), 32'(TARGET));
      check(period_bad == 0, "R2 sck period", 32'(period_bad), 32'h0);
      check(stable_bad == 0, "R3 change only on falling sck", 32'(stable_bad), 32'h0);
      check(lr_bad == 0, "R3 lrck slot level", 32'(lr_bad), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule